// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block runs external bus cycles for a 16-bit bus master. An internal requester hands it one transfer at a time: address, function code, size, direction, write data, and flags that mark an interrupt acknowledge or an internal-only access. The block drives the address and control lines and the address strobe, and it enables the data drivers on writes. It then waits for the cycle to end. A cycle ends on a data/size acknowledge, on an autovector input (interrupt acknowledge cycles only), or on a bus error. The bus error can come from a pin or from a built-in bus monitor that times out the strobe.

A halt input puts the block into single-cycle operation. After each external cycle the block parks with the strobe and data drivers off and the address and control lines frozen. It inhibits interrupt servicing until halt drops. A bus error that arrives while halt is asserted is not reported. The same cycle is run again once halt is released. An external-master-present input takes the drivers off the bus and stops the bus monitor. When mastership returns, the frozen address and control values are driven again.

All termination and halt pins pass through a two-flop synchronizer, so the state machine sees them two clocks late.

Top module: `bus_term_ctl`

## Requirements
- R1: An external cycle whose acknowledge (either bit of `dsackIn`, active high) is already settled ends with one `cycleDone` pulse after exactly 2 clocks of `addrStrobe`. A read captures `dataIn` into `rdData`. A write drives `dataOut` equal to the request data with `dataOe` high while the strobe is on.
- R2: If bus error and acknowledge are both present, the cycle ends with `cycleBerr` and no `cycleDone`. Bus error wins.
- R3: If a cycle gets no termination, the bus monitor ends it with `cycleBerr` after `addrStrobe` has been high for L clocks. L is `monLimit` clamped to the range 8..64.
- R4: While `extMaster` is high the bus monitor neither counts nor times out. A cycle stalled under an external master ends normally by acknowledge once the master leaves.
- R5: `avecIn` ends a cycle only when `reqIack` was set for that cycle. In any other cycle it is ignored, and that cycle runs to a monitor timeout.
- R6: A cycle completed while halt is asserted leaves the block halted. `intInhibit` is high, `addrStrobe` and `dataOe` are low, and `busAddr`/`busRw` keep the cycle's values until halt is released. After release `intInhibit` falls.
- R7: Bus error with halt asserted gives no `cycleBerr`. After halt is released the same address is strobed again, and the cycle then ends by acknowledge with `cycleDone`.
- R8: An internal-only request (`reqInternal` high) is accepted even while halted. It gives `cycleDone` one clock after acceptance without any strobe.
- R9: `busDrive` is low whenever `extMaster` is high. When mastership returns with halt still asserted, `busDrive` rises and `busAddr` shows the pre-release value.
- R10: After reset the strobe, `dataOe`, `cycleDone`, `cycleBerr` and `intInhibit` are low, and `busDrive` and `reqReady` are high.
- R11: `reqReady` is low for an external request while halted or while `extMaster` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Request accepted this clock |
| reqInternal | input | 1 | Request needs no external bus |
| reqIack | input | 1 | Request is an interrupt acknowledge |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqAddr | input | 24 | Request address |
| reqFc | input | 3 | Request function code |
| reqSize | input | 2 | Request size code |
| reqData | input | 16 | Write data |
| monLimit | input | 7 | Bus monitor limit in clocks (clamped 8..64) |
| dsackIn | input | 2 | Data/size acknowledge pair, active high |
| avecIn | input | 1 | Autovector termination, active high |
| berrIn | input | 1 | Bus error pin, active high |
| haltIn | input | 1 | Halt request, active high |
| extMaster | input | 1 | Another master owns the bus |
| dataIn | input | 16 | Read data from the bus |
| busAddr | output | 24 | Address lines |
| busFc | output | 3 | Function code lines |
| busSize | output | 2 | Size lines |
| busRw | output | 1 | Read/write line, 1 = read |
| busDrive | output | 1 | Address/control driver enable |
| addrStrobe | output | 1 | Address strobe, active high |
| dataOe | output | 1 | Data bus driver enable |
| dataOut | output | 16 | Data driven on writes |
| rdData | output | 16 | Last captured read data |
| cycleDone | output | 1 | Cycle ended normally (one clock) |
| cycleBerr | output | 1 | Cycle ended in bus error exception (one clock) |
| intInhibit | output | 1 | Interrupt servicing inhibited while halted |

## Verification
The bench goes after the termination priority. It asserts bus error with acknowledge, where a design giving acknowledge priority would report a normal end. It times the monitor at both clamp edges, where an off-by-one or an unclamped limit shows as a wrong strobe length. It feeds an autovector into a plain cycle, which a careless design would end early. The halt paths are checked at the ports. A faulted cycle under halt must re-strobe its own address with no exception. The frozen address must survive a visit by an external master. An internal request must slip through while halted, and a design that gated it on halt would hang there.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  typedef enum logic [6:0] {
    ST_IDLE   = 7'b0000001,
    ST_ADDR   = 7'b0000010,
    ST_WAIT   = 7'b0000100,
    ST_END    = 7'b0001000,
    ST_HALTED = 7'b0010000,
    ST_RETRY  = 7'b0100000,
    ST_BERR   = 7'b1000000
  } busState_t;

  typedef struct packed {
    logic load;     // capture a new external request
    logic capRd;    // capture read data on normal end
    logic strobe;   // address strobe phase
    logic dataDrv;  // write data phase
  } busStrobe_t;

endpackage

// File: rtl/bus_term_sync.sv
module bus_term_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bus_term_pkg::*;
#(
  parameter int MONW    = 7,
  parameter int MON_MIN = 8,
  parameter int MON_MAX = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqInternal,
  input  logic            reqIack,
  input  logic            reqWrite,
  input  logic [MONW-1:0] monLimit,
  input  logic [1:0]      dsackS,
  input  logic            avecS,
  input  logic            berrS,
  input  logic            haltS,
  input  logic            extMaster,
  output logic            reqReady,
  output busStrobe_t      strb,
  output logic            cycleDone,
  output logic            cycleBerr,
  output logic            intInhibit,
  output busState_t       stateOut
);
  localparam logic [MONW-1:0] LIM_LO  = MONW'(MON_MIN);
  localparam logic [MONW-1:0] LIM_HI  = MONW'(MON_MAX);
  localparam logic [MONW-1:0] CNT_TOP = {MONW{1'b1}};

  busState_t       state, nextState;
  logic            retryPend, intAck, iackQ, writeQ;
  logic [MONW-1:0] monCnt, limC;
  logic            accept, inCycle, monExpire, berrHit, normHit;

  always_comb begin
    if (monLimit < LIM_LO)      limC = LIM_LO;
    else if (monLimit > LIM_HI) limC = LIM_HI;
    else                        limC = monLimit;
  end

  assign inCycle   = (state == ST_ADDR) || (state == ST_WAIT);
  assign monExpire = !extMaster && (monCnt >= limC - 1'b1);
  assign berrHit   = berrS || monExpire;
  assign normHit   = (|dsackS) || (avecS && iackQ && !extMaster);

  always_comb begin
    reqReady = ((state == ST_IDLE) && (reqInternal || (!haltS && !extMaster)))
            || ((state == ST_HALTED) && reqInternal);
  end
  assign accept = reqValid && reqReady;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (haltS)                          nextState = ST_HALTED;
        else if (accept && !reqInternal)    nextState = ST_ADDR;
      end
      ST_ADDR:   nextState = ST_WAIT;
      ST_WAIT: begin
        if (berrHit)      nextState = haltS ? ST_HALTED : ST_BERR;
        else if (normHit) nextState = ST_END;
      end
      ST_END:    nextState = haltS ? ST_HALTED : ST_IDLE;
      ST_BERR:   nextState = ST_IDLE;
      ST_HALTED: if (!haltS) nextState = retryPend ? ST_RETRY : ST_IDLE;
      ST_RETRY:  if (!extMaster) nextState = ST_ADDR;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      retryPend <= 1'b0;
      intAck    <= 1'b0;
      iackQ     <= 1'b0;
      writeQ    <= 1'b0;
      monCnt    <= '0;
    end else begin
      state  <= nextState;
      intAck <= accept && reqInternal;
      if (accept && !reqInternal) begin
        iackQ  <= reqIack;
        writeQ <= reqWrite;
      end
      if (state == ST_WAIT && berrHit && haltS)
        retryPend <= 1'b1;
      else if (state == ST_HALTED && !haltS)
        retryPend <= 1'b0;
      if (!inCycle)
        monCnt <= '0;
      else if (!extMaster && monCnt != CNT_TOP)
        monCnt <= monCnt + 1'b1;
    end
  end

  always_comb begin
    strb.load    = accept && !reqInternal;
    strb.capRd   = (state == ST_WAIT) && !berrHit && normHit;
    strb.strobe  = inCycle;
    strb.dataDrv = inCycle && writeQ;
  end

  assign cycleDone  = (state == ST_END) || intAck;
  assign cycleBerr  = (state == ST_BERR);
  assign intInhibit = (state == ST_HALTED);
  assign stateOut   = state;
endmodule

// File: rtl/bus_term_dp.sv
module bus_term_dp
  import bus_term_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  busStrobe_t    strb,
  input  logic [AW-1:0] reqAddr,
  input  logic [2:0]    reqFc,
  input  logic [1:0]    reqSize,
  input  logic          reqWrite,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] dataIn,
  input  logic          extMaster,
  output logic [AW-1:0] busAddr,
  output logic [2:0]    busFc,
  output logic [1:0]    busSize,
  output logic          busRw,
  output logic          busDrive,
  output logic          addrStrobe,
  output logic          dataOe,
  output logic [DW-1:0] dataOut,
  output logic [DW-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr <= '0;
      busFc   <= '0;
      busSize <= '0;
      busRw   <= 1'b1;
      dataOut <= '0;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        busAddr <= reqAddr;
        busFc   <= reqFc;
        busSize <= reqSize;
        busRw   <= !reqWrite;
        dataOut <= reqData;
      end
      if (strb.capRd && busRw)
        rdData <= dataIn;
    end
  end

  assign busDrive   = !extMaster;
  assign addrStrobe = strb.strobe && !extMaster;
  assign dataOe     = strb.dataDrv && !extMaster;
endmodule

// File: rtl/bus_term_ctl.sv
module bus_term_ctl
  import bus_term_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int MONW    = 7,
  parameter int MON_MIN = 8,
  parameter int MON_MAX = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqInternal,
  input  logic            reqIack,
  input  logic            reqWrite,
  input  logic [AW-1:0]   reqAddr,
  input  logic [2:0]      reqFc,
  input  logic [1:0]      reqSize,
  input  logic [DW-1:0]   reqData,
  input  logic [MONW-1:0] monLimit,
  input  logic [1:0]      dsackIn,
  input  logic            avecIn,
  input  logic            berrIn,
  input  logic            haltIn,
  input  logic            extMaster,
  input  logic [DW-1:0]   dataIn,
  output logic [AW-1:0]   busAddr,
  output logic [2:0]      busFc,
  output logic [1:0]      busSize,
  output logic            busRw,
  output logic            busDrive,
  output logic            addrStrobe,
  output logic            dataOe,
  output logic [DW-1:0]   dataOut,
  output logic [DW-1:0]   rdData,
  output logic            cycleDone,
  output logic            cycleBerr,
  output logic            intInhibit
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0] pinRaw, pinSync;
  busStrobe_t        strb;
  busState_t         ctlState;

  assign pinRaw = {dsackIn, avecIn, berrIn, haltIn};

  bus_term_sync #(.W(SYNC_W)) uSync (
    .clk(clk), .rstN(rstN), .din(pinRaw), .dout(pinSync)
  );

  bus_term_ctrl #(.MONW(MONW), .MON_MIN(MON_MIN), .MON_MAX(MON_MAX)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqInternal(reqInternal), .reqIack(reqIack),
    .reqWrite(reqWrite), .monLimit(monLimit),
    .dsackS(pinSync[4:3]), .avecS(pinSync[2]), .berrS(pinSync[1]),
    .haltS(pinSync[0]), .extMaster(extMaster),
    .reqReady(reqReady), .strb(strb), .cycleDone(cycleDone),
    .cycleBerr(cycleBerr), .intInhibit(intInhibit), .stateOut(ctlState)
  );

  bus_term_dp #(.AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqFc(reqFc), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqData(reqData), .dataIn(dataIn),
    .extMaster(extMaster),
    .busAddr(busAddr), .busFc(busFc), .busSize(busSize), .busRw(busRw),
    .busDrive(busDrive), .addrStrobe(addrStrobe), .dataOe(dataOe),
    .dataOut(dataOut), .rdData(rdData)
  );
endmodule

// File: rtl/bus_term_chk.sv
module bus_term_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          extMaster,
  input logic          addrStrobe,
  input logic          dataOe,
  input logic          busDrive,
  input logic [AW-1:0] busAddr,
  input logic          cycleDone,
  input logic          cycleBerr,
  input logic          intInhibit,
  input logic [6:0]    ctlState
);
  logic [7:0] strobeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  strobeRun <= '0;
    else if (!addrStrobe)       strobeRun <= '0;
    else if (strobeRun != 8'hFF) strobeRun <= strobeRun + 8'd1;
  end

  a_r3_strobe_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobeRun <= 8'd64);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleDone && cycleBerr));

  a_r6_quiet_halted: assert property (@(posedge clk) disable iff (!rstN)
    intInhibit |-> (!addrStrobe && !dataOe));

  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (intInhibit && $past(intInhibit)) |-> $stable(busAddr));

  a_r9_release_bus: assert property (@(posedge clk) disable iff (!rstN)
    extMaster |-> (!busDrive && !addrStrobe));

  a_fsm_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ctlState));
endmodule

bind bus_term_ctl bus_term_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .extMaster(extMaster), .addrStrobe(addrStrobe),
  .dataOe(dataOe), .busDrive(busDrive), .busAddr(busAddr),
  .cycleDone(cycleDone), .cycleBerr(cycleBerr), .intInhibit(intInhibit),
  .ctlState(ctlState)
);

// File: tb/bus_term_ctl_bench.sv
module bus_term_ctl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqInternal = 0, reqIack = 0, reqWrite = 0;
  logic [23:0] reqAddr = '0;
  logic [2:0]  reqFc = '0;
  logic [1:0]  reqSize = 2'b01;
  logic [15:0] reqData = '0;
  logic [6:0]  monLimit = 7'd16;
  logic [1:0]  dsackIn = '0;
  logic        avecIn = 0, berrIn = 0, haltIn = 0, extMaster = 0;
  logic [15:0] dataIn;
  logic [23:0] busAddr;
  logic [2:0]  busFc;
  logic [1:0]  busSize;
  logic        busRw, busDrive, addrStrobe, dataOe, reqReady;
  logic [15:0] dataOut, rdData;
  logic        cycleDone, cycleBerr, intInhibit;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 4 ns period

  assign dataIn = busAddr[15:0] ^ 16'hA5C3;

  bus_term_ctl u_bus_term_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqInternal(reqInternal), .reqIack(reqIack), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqFc(reqFc), .reqSize(reqSize), .reqData(reqData),
    .monLimit(monLimit), .dsackIn(dsackIn), .avecIn(avecIn), .berrIn(berrIn),
    .haltIn(haltIn), .extMaster(extMaster), .dataIn(dataIn),
    .busAddr(busAddr), .busFc(busFc), .busSize(busSize), .busRw(busRw),
    .busDrive(busDrive), .addrStrobe(addrStrobe), .dataOe(dataOe),
    .dataOut(dataOut), .rdData(rdData), .cycleDone(cycleDone),
    .cycleBerr(cycleBerr), .intInhibit(intInhibit)
  );

  // kind: 0 acknowledge, 1 bus error with acknowledge, 2 nothing, 3 autovector
  localparam int NV = 8;
  localparam logic [23:0] V_ADDR [NV] = '{24'h001000, 24'h0A0022, 24'h003344, 24'h120000,
                                          24'h000010, 24'h7FFFFE, 24'hFFFFF0, 24'h000200};
  localparam logic        V_WR   [NV] = '{0, 1, 0, 0, 0, 0, 0, 0};
  localparam logic        V_IACK [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
  localparam int          V_KIND [NV] = '{0, 0, 1, 2, 2, 2, 3, 3};
  localparam int          V_LIM  [NV] = '{20, 20, 20, 12, 3, 100, 20, 9};

  function automatic int clampLim(int l);
    return (l < 8) ? 8 : (l > 64) ? 64 : l;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Issue one external request and observe until it ends.
  task automatic runTxn(input logic [23:0] a, input logic wr, input logic iack,
                        input int kind, input int lim,
                        output int strobes, output bit gotDone, output bit gotBerr,
                        output bit sawOe, output logic [15:0] oeData,
                        output logic [15:0] rd);
    @(negedge clk);
    monLimit = 7'(lim);
    dsackIn  = (kind == 0 || kind == 1) ? 2'b10 : 2'b00;
    berrIn   = (kind == 1);
    avecIn   = (kind == 3);
    waitN(3);
    reqValid = 1; reqInternal = 0; reqIack = iack; reqWrite = wr;
    reqAddr = a; reqFc = iack ? 3'b111 : 3'b001; reqData = ~a[15:0];
    @(negedge clk);
    reqValid = 0;
    strobes = 0; gotDone = 0; gotBerr = 0; sawOe = 0; oeData = '0; rd = '0;
    for (int i = 0; i < 300; i++) begin
      if (addrStrobe) strobes++;
      if (dataOe) begin sawOe = 1; oeData = dataOut; end
      if (cycleDone) begin gotDone = 1; rd = rdData; break; end
      if (cycleBerr) begin gotBerr = 1; break; end
      @(negedge clk);
    end
    dsackIn = 0; berrIn = 0; avecIn = 0;
    waitN(4);
  endtask

  initial begin
    #(4ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int strobes, n;
    bit gd, gb, oe, seenBerr;
    logic [15:0] od, rd;
    logic [23:0] held;

    waitN(3);
    @(negedge clk);
    // R10: reset state
    check(!addrStrobe && !dataOe && !cycleDone && !cycleBerr && !intInhibit, "R10",
          "idle outputs", {addrStrobe, dataOe, cycleDone, cycleBerr, intInhibit}, 0);
    check(busDrive && reqReady, "R10", "drive and ready", {busDrive, reqReady}, 2'b11);
    rstN = 1;
    waitN(2);

    // Table of vectors: R1, R2, R3, R5
    for (int v = 0; v < NV; v++) begin
      runTxn(V_ADDR[v], V_WR[v], V_IACK[v], V_KIND[v], V_LIM[v], strobes, gd, gb, oe, od, rd);
      if (V_KIND[v] == 0 || (V_KIND[v] == 3 && V_IACK[v])) begin
        check(gd && !gb, (V_KIND[v] == 0) ? "R1" : "R5", "normal end", {gd, gb}, 2'b10);
        check(strobes == 2, (V_KIND[v] == 0) ? "R1" : "R5", "strobe clocks", strobes, 2);
        if (V_KIND[v] == 0 && !V_WR[v])
          check(rd == (V_ADDR[v][15:0] ^ 16'hA5C3), "R1", "read data", rd, V_ADDR[v][15:0] ^ 16'hA5C3);
        if (V_WR[v])
          check(oe && od == ~V_ADDR[v][15:0], "R1", "write data", od, ~V_ADDR[v][15:0]);
      end else begin
        check(gb && !gd, (V_KIND[v] == 1) ? "R2" : (V_KIND[v] == 3) ? "R5" : "R3",
              "bus error end", {gd, gb}, 2'b01);
        n = (V_KIND[v] == 1) ? 2 : clampLim(V_LIM[v]);
        check(strobes == n, (V_KIND[v] == 1) ? "R2" : (V_KIND[v] == 3) ? "R5" : "R3",
              "strobe clocks", strobes, n);
      end
    end

    // R4: monitor stopped under an external master
    monLimit = 7'd8;
    reqValid = 1; reqInternal = 0; reqIack = 0; reqWrite = 0; reqAddr = 24'h004400;
    @(negedge clk);
    reqValid = 0; extMaster = 1;
    seenBerr = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (cycleBerr) seenBerr = 1; end
    check(!seenBerr, "R4", "no timeout with external master", seenBerr, 0);
    dsackIn = 2'b01; extMaster = 0;
    gd = 0; gb = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cycleDone) gd = 1;
      if (cycleBerr) gb = 1;
    end
    check(gd && !gb, "R4", "ends by acknowledge", {gd, gb}, 2'b10);
    dsackIn = 0; waitN(4);

    // R6: halt after a cycle
    monLimit = 7'd64;
    reqValid = 1; reqWrite = 0; reqAddr = 24'h00BEEF;
    @(negedge clk);
    reqValid = 0; haltIn = 1;
    waitN(4);
    dsackIn = 2'b10;
    waitN(6);
    dsackIn = 0;
    waitN(3);
    check(intInhibit && !addrStrobe && !dataOe, "R6", "halted quiet",
          {intInhibit, addrStrobe, dataOe}, 3'b100);
    check(busAddr == 24'h00BEEF && busRw, "R6", "address held", busAddr, 24'h00BEEF);
    // R11: external request refused while halted
    reqValid = 1; reqInternal = 0; reqAddr = 24'h00AAAA;
    #1;
    check(!reqReady, "R11", "ready while halted", reqReady, 0);
    // R8: internal request completes while halted
    reqInternal = 1;
    @(negedge clk);
    reqValid = 0; reqInternal = 0;
    check(cycleDone && !addrStrobe, "R8", "internal done", {cycleDone, addrStrobe}, 2'b10);
    // R9: mastership visit while halted
    extMaster = 1;
    #1;
    check(!busDrive, "R9", "drive off under master", busDrive, 0);
    reqValid = 1;
    #1;
    check(!reqReady, "R11", "ready under master", reqReady, 0);
    reqValid = 0;
    waitN(5);
    extMaster = 0;
    @(negedge clk);
    check(busDrive && busAddr == 24'h00BEEF, "R9", "re-driven address", busAddr, 24'h00BEEF);
    haltIn = 0;
    waitN(4);
    check(!intInhibit, "R6", "released", intInhibit, 0);

    // R7: bus error under halt retries the cycle
    reqValid = 1; reqWrite = 0; reqAddr = 24'h0C0DE0;
    @(negedge clk);
    reqValid = 0; haltIn = 1; berrIn = 1;
    seenBerr = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (cycleBerr) seenBerr = 1; end
    berrIn = 0;
    waitN(4);
    check(intInhibit && !seenBerr, "R7", "halted, no exception", {intInhibit, seenBerr}, 2'b10);
    dsackIn = 2'b11; haltIn = 0;
    strobes = 0; gd = 0; held = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (addrStrobe) begin strobes++; held = busAddr; end
      if (cycleBerr) seenBerr = 1;
      if (cycleDone) begin gd = 1; break; end
    end
    check(gd && !seenBerr && strobes == 2, "R7", "retried cycle ends", strobes, 2);
    check(held == 24'h0C0DE0, "R7", "retry address", held, 24'h0C0DE0);
    dsackIn = 0;
    waitN(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule